// File: doc/BRIEF.md
# LCD Controller Host Bus Interface

This block is the parallel host port of a graphic LCD controller. A host processor reaches an 8-bit-per-byte display memory of 4 pages by 80 columns (2560 bits) through it. The port also accepts commands that set the write/read position and a few mode flags. The same pins serve either an enable-plus-direction bus (E with R/W) or a split-strobe bus (active-low RD and WR). The style is chosen by the level on `bus_style` while the block is held in reset.

The A0 input selects between the display memory and the command/status path. Display reads are pipelined through a read latch. Each read drives the value captured by the previous read and then reloads the latch from the current address, so a run of reads begins with one dummy read. Writes go straight to memory. A column counter advances on every accepted display access and stops at 0x50. A busy window of `BUSY_CYC` clocks follows each command or display write. During that window only status reads are honoured.

All host pins are taken to be synchronous to `clk`. An access takes effect on the first clock edge at which its strobe is seen inactive, using the A0 and data values sampled one edge earlier.

Top module: `lcd_host_if`

## Requirements
- R1: While `rst_n` is low, `bus_style`=1 selects enable mode (`en_rd` is an active-high enable, `rw_wr`=1 read / 0 write) and `bus_style`=0 selects strobe mode (`en_rd` is active-low read, `rw_wr` is active-low write); the choice holds after reset.
- R2: A0=1 addresses display memory for reads and writes; A0=0 makes a write a command and a read a status read.
- R3: A display read drives the read latch, then loads the latch from the byte at (page, column); a run of reads starts with one dummy read.
- R4: A display write stores the byte at (page, column) with no dummy cycle, and the column then advances by one.
- R5: The column counter advances on each accepted display access only while below 0x50 and never wraps. At column 0x50, writes store nothing and reads load 0x00. A column preset above 0x50 is clamped to 0x50.
- R6: Command codes: 0b0ccccccc presets the column; 0b101110pp loads the page; 0xAE/0xAF turn the display off/on; 0xE0 enters read-modify-write; 0xEE leaves it.
- R7: A status byte has bit 7 = busy, bit 5 = display off, and all other bits 0.
- R8: Busy is set for `BUSY_CYC` clocks after each accepted command or display write. While busy, display reads, display writes and commands are ignored, and status reads work.
- R9: `d_oe` is high only while chip select is low and the read strobe is active. In strobe mode, a write takes effect when WR returns high.
- R10: With `cs_n` high, no access has any effect and `d_oe` stays low.
- R11: After reset: column 0, page 3, display off, read-modify-write off, not busy.
- R12: In read-modify-write mode, display reads do not advance the column; display writes still do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_style | input | 1 | Bus style strap, sampled during reset (1 = enable mode) |
| cs_n | input | 1 | Chip select, active low |
| a0 | input | 1 | Data (1) or command/status (0) select |
| en_rd | input | 1 | E (enable mode) or RD_n (strobe mode) |
| rw_wr | input | 1 | R/W (enable mode) or WR_n (strobe mode) |
| d_in | input | 8 | Write data from the host |
| d_out | output | 8 | Read data to the host |
| d_oe | output | 1 | Data bus drive enable |

## Verification
The busy window and a new access can fall together. The bench issues a page command and then, at once, a second page command and a status read while the first command's busy count is still running. It judges the result in two ways: the status byte read in that window must show bit 7 set, and a later display write must land in the page set by the first command. The column limit and a display write also meet. Writes at column 0x4F and beyond are followed by a read of column 0, which must still hold its old byte, proving the counter stopped rather than wrapped.

// File: rtl/lcd_if_pkg.sv
// Package: shared types and command codes of the LCD host interface.
// Assumes: 8-bit host data bus, at most 4 pages.
package lcd_if_pkg;
    typedef enum logic {BUS_STROBE = 1'b0, BUS_ENABLE = 1'b1} bus_style_e;

    localparam logic [7:0] CMD_PAGE_MASK = 8'hFC;
    localparam logic [7:0] CMD_PAGE      = 8'hB8;
    localparam logic [7:0] CMD_DISP_MASK = 8'hFE;
    localparam logic [7:0] CMD_DISP      = 8'hAE;
    localparam logic [7:0] CMD_RMW_ON    = 8'hE0;
    localparam logic [7:0] CMD_RMW_OFF   = 8'hEE;

    typedef struct packed {
        logic       rd_go;  // a read strobe just ended
        logic       wr_go;  // a write strobe just ended
        logic       a0;     // A0 sampled while the strobe was active
        logic [7:0] data;   // write data sampled while the strobe was active
    } bus_evt_t;
endpackage

// File: rtl/lcd_bus_front.sv
// Module: lcd_bus_front
// Turns the host pins of either bus style into one end-of-access event per
// read or write. Assumes pins are synchronous to clk and stable for at least
// one clock edge while the strobe is active.
module lcd_bus_front
    import lcd_if_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     bus_style,
    input  logic     cs_n,
    input  logic     a0,
    input  logic     en_rd,
    input  logic     rw_wr,
    input  logic [7:0] d_in,
    output logic     rd_act,
    output bus_evt_t evt
);
    bus_style_e mode_q;
    logic       wr_act;
    logic       p_rd, p_wr, p_a0;
    logic [7:0] p_d;

    // Latch the bus style from the strap while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= bus_style_e'(bus_style);
    end

    // Decode the active read/write strobe for the selected style.
    always_comb begin
        if (mode_q == BUS_ENABLE) begin
            rd_act = !cs_n && en_rd && rw_wr;
            wr_act = !cs_n && en_rd && !rw_wr;
        end else begin
            rd_act = !cs_n && !en_rd;
            wr_act = !cs_n && !rw_wr;
        end
    end

    // Remember strobe state, A0 and data from the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_rd <= 1'b0;
            p_wr <= 1'b0;
            p_a0 <= 1'b0;
            p_d  <= '0;
        end else begin
            p_rd <= rd_act;
            p_wr <= wr_act;
            p_a0 <= a0;
            p_d  <= d_in;
        end
    end

    // An access completes on the edge its strobe is first seen inactive.
    always_comb begin
        evt.rd_go = p_rd && !rd_act;
        evt.wr_go = p_wr && !wr_act;
        evt.a0    = p_a0;
        evt.data  = p_d;
    end
endmodule

// File: rtl/lcd_dram.sv
// Module: lcd_dram
// Display memory of PAGES x COLS bytes, synchronous write, combinational read.
// Assumes the caller only writes in-range columns; out-of-range reads return 0.
module lcd_dram #(
    parameter int COLS  = 80,
    parameter int PAGES = 4,
    localparam int CW    = $clog2(COLS + 1),
    localparam int PW    = (PAGES > 1) ? $clog2(PAGES) : 1,
    localparam int DEPTH = PAGES * COLS,
    localparam int AW    = $clog2(DEPTH + COLS + 1)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [PW-1:0] page,
    input  logic [CW-1:0] col,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] idx;

    // Linear byte index of (page, column).
    assign idx = AW'(page) * AW'(COLS) + AW'(col);

    // Store a byte on an accepted write.
    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
    end

    // Return the addressed byte, zero when out of range.
    assign rdata = (idx < AW'(DEPTH)) ? mem[idx] : 8'h00;
endmodule

// File: rtl/lcd_ctrl_core.sv
// Module: lcd_ctrl_core
// Address counters, mode flags, busy timer and read latch. Consumes one bus
// event per access. Assumes PAGES <= 4 and COLS <= 127.
module lcd_ctrl_core
    import lcd_if_pkg::*;
#(
    parameter int COLS     = 80,
    parameter int PAGES    = 4,
    parameter int BUSY_CYC = 12,
    localparam int CW = $clog2(COLS + 1),
    localparam int PW = (PAGES > 1) ? $clog2(PAGES) : 1,
    localparam int BW = $clog2(BUSY_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  bus_evt_t      evt,
    input  logic [7:0]    ram_rdata,
    output logic          ram_we,
    output logic [CW-1:0] col_q,
    output logic [PW-1:0] page_q,
    output logic [7:0]    latch_q,
    output logic [7:0]    status,
    output logic          busy,
    output logic          rmw_q,
    output logic          cmd_go,
    output logic          dwr_go,
    output logic          drd_go
);
    logic [BW-1:0] bcnt_q;
    logic          disp_on_q;
    logic          col_ok;

    // Qualify events: nothing but status reads while busy.
    always_comb begin
        busy   = (bcnt_q != '0);
        cmd_go = evt.wr_go && !evt.a0 && !busy;
        dwr_go = evt.wr_go &&  evt.a0 && !busy;
        drd_go = evt.rd_go &&  evt.a0 && !busy;
        col_ok = (col_q < CW'(COLS));
        ram_we = dwr_go && col_ok;
        status = {busy, 1'b0, !disp_on_q, 5'b0};
    end

    // Column counter: preset with clamp, saturating advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
        end else if (cmd_go && !evt.data[7]) begin
            col_q <= (evt.data[6:0] > 7'(COLS)) ? CW'(COLS) : CW'(evt.data[6:0]);
        end else if ((dwr_go || (drd_go && !rmw_q)) && col_ok) begin
            col_q <= col_q + 1'b1;
        end
    end

    // Page register, mode flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q    <= PW'(PAGES - 1);
            disp_on_q <= 1'b0;
            rmw_q     <= 1'b0;
        end else if (cmd_go) begin
            if ((evt.data & CMD_PAGE_MASK) == CMD_PAGE) page_q <= evt.data[PW-1:0];
            if ((evt.data & CMD_DISP_MASK) == CMD_DISP) disp_on_q <= evt.data[0];
            if (evt.data == CMD_RMW_ON)  rmw_q <= 1'b1;
            if (evt.data == CMD_RMW_OFF) rmw_q <= 1'b0;
        end
    end

    // Busy timer, reloaded by each accepted command or display write.
    always_ff @(posedge clk) begin
        if (!rst_n)                bcnt_q <= '0;
        else if (cmd_go || dwr_go) bcnt_q <= BW'(BUSY_CYC);
        else if (busy)             bcnt_q <= bcnt_q - 1'b1;
    end

    // Read latch, reloaded from memory at the end of each display read.
    always_ff @(posedge clk) begin
        if (!rst_n)      latch_q <= '0;
        else if (drd_go) latch_q <= col_ok ? ram_rdata : 8'h00;
    end
endmodule

// File: rtl/lcd_host_if.sv
// Module: lcd_host_if (top)
// Host bus port of an LCD controller: bus front end, control core and display
// memory. The data bus is split into d_in/d_out with a drive enable.
module lcd_host_if
    import lcd_if_pkg::*;
#(
    parameter int COLS     = 80,
    parameter int PAGES    = 4,
    parameter int BUSY_CYC = 12,
    localparam int CW = $clog2(COLS + 1),
    localparam int PW = (PAGES > 1) ? $clog2(PAGES) : 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_style,
    input  logic       cs_n,
    input  logic       a0,
    input  logic       en_rd,
    input  logic       rw_wr,
    input  logic [7:0] d_in,
    output logic [7:0] d_out,
    output logic       d_oe
);
    bus_evt_t      evt;
    logic          rd_act, ram_we, busy, rmw_q, cmd_go, dwr_go, drd_go;
    logic [CW-1:0] col_q;
    logic [PW-1:0] page_q;
    logic [7:0]    latch_q, status, ram_rdata;

    lcd_bus_front u_front (
        .clk(clk), .rst_n(rst_n), .bus_style(bus_style), .cs_n(cs_n),
        .a0(a0), .en_rd(en_rd), .rw_wr(rw_wr), .d_in(d_in),
        .rd_act(rd_act), .evt(evt)
    );

    lcd_ctrl_core #(.COLS(COLS), .PAGES(PAGES), .BUSY_CYC(BUSY_CYC)) u_core (
        .clk(clk), .rst_n(rst_n), .evt(evt), .ram_rdata(ram_rdata),
        .ram_we(ram_we), .col_q(col_q), .page_q(page_q), .latch_q(latch_q),
        .status(status), .busy(busy), .rmw_q(rmw_q), .cmd_go(cmd_go),
        .dwr_go(dwr_go), .drd_go(drd_go)
    );

    lcd_dram #(.COLS(COLS), .PAGES(PAGES)) u_dram (
        .clk(clk), .we(ram_we), .page(page_q), .col(col_q),
        .wdata(evt.data), .rdata(ram_rdata)
    );

    // Drive the latch or the status byte while a read strobe is active.
    assign d_out = a0 ? latch_q : status;
    assign d_oe  = rd_act;
endmodule

// File: rtl/lcd_host_if_chk.sv
// Module: lcd_host_if_chk
// Protocol and state checks for lcd_host_if, attached by bind.
module lcd_host_if_chk #(
    parameter int COLS  = 80,
    parameter int PAGES = 4,
    parameter int CW    = 7,
    parameter int PW    = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          a0,
    input logic          d_oe,
    input logic [7:0]    d_out,
    input logic [CW-1:0] col_q,
    input logic [PW-1:0] page_q,
    input logic          busy,
    input logic          rmw_q,
    input logic          cmd_go,
    input logic          dwr_go,
    input logic          drd_go
);
    assert_oe_needs_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        d_oe |-> !cs_n);

    assert_status_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (d_oe && !a0) |-> (d_out[7] == busy));

    assert_busy_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(col_q) && $stable(page_q)));

    assert_col_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (col_q == CW'(COLS) && !cmd_go) |=> (col_q == CW'(COLS)));

    assert_wr_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dwr_go && col_q < CW'(COLS)) |=> (col_q == CW'($past(col_q) + 1'b1)));

    assert_rmw_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (drd_go && rmw_q) |=> $stable(col_q));

    assert_reset_state_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (col_q == '0 && page_q == PW'(PAGES - 1) && !busy && !rmw_q));
endmodule

bind lcd_host_if lcd_host_if_chk #(.COLS(COLS), .PAGES(PAGES), .CW(CW), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .a0(a0), .d_oe(d_oe), .d_out(d_out),
    .col_q(col_q), .page_q(page_q), .busy(busy), .rmw_q(rmw_q),
    .cmd_go(cmd_go), .dwr_go(dwr_go), .drd_go(drd_go)
);

// File: tb/lcd_host_if_bench.sv
// Bench for lcd_host_if: a vector table walked in strobe mode, then directed
// tests for reset, busy overlap, chip select and enable mode.
module lcd_host_if_bench;
    localparam int BUSY_CYC = 12;
    // op: 0 command write, 1 display write, 2 display read checked, 3 dummy read
    localparam int NV = 39;
    localparam logic [17:0] VEC [NV] = '{
        {2'd0, 8'hB8, 8'h00}, {2'd0, 8'h05, 8'h00}, {2'd1, 8'hAA, 8'h00},
        {2'd1, 8'h55, 8'h00}, {2'd1, 8'hC3, 8'h00}, {2'd0, 8'h05, 8'h00},
        {2'd3, 8'h00, 8'h00}, {2'd2, 8'h00, 8'hAA}, {2'd2, 8'h00, 8'h55},
        {2'd2, 8'h00, 8'hC3}, {2'd0, 8'hB9, 8'h00}, {2'd0, 8'h00, 8'h00},
        {2'd1, 8'h77, 8'h00}, {2'd0, 8'h4F, 8'h00}, {2'd1, 8'h11, 8'h00},
        {2'd1, 8'h22, 8'h00}, {2'd1, 8'h33, 8'h00}, {2'd0, 8'h00, 8'h00},
        {2'd3, 8'h00, 8'h00}, {2'd2, 8'h00, 8'h77}, {2'd0, 8'h4F, 8'h00},
        {2'd3, 8'h00, 8'h00}, {2'd2, 8'h00, 8'h11}, {2'd2, 8'h00, 8'h00},
        {2'd0, 8'h7F, 8'h00}, {2'd3, 8'h00, 8'h00}, {2'd2, 8'h00, 8'h00},
        {2'd0, 8'hB8, 8'h00}, {2'd0, 8'h05, 8'h00}, {2'd0, 8'hE0, 8'h00},
        {2'd3, 8'h00, 8'h00}, {2'd2, 8'h00, 8'hAA}, {2'd1, 8'hF0, 8'h00},
        {2'd0, 8'hEE, 8'h00}, {2'd3, 8'h00, 8'h00}, {2'd2, 8'h00, 8'h55},
        {2'd0, 8'h05, 8'h00}, {2'd3, 8'h00, 8'h00}, {2'd2, 8'h00, 8'hF0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_style = 1'b0;
    logic cs_n = 1'b1;
    logic a0 = 1'b0;
    logic en_rd = 1'b1;
    logic rw_wr = 1'b1;
    logic [7:0] d_in = '0;
    logic [7:0] d_out;
    logic d_oe;
    logic m68 = 1'b0;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lcd_host_if #(.BUSY_CYC(BUSY_CYC)) u_lcd_host_if (
        .clk(clk), .rst_n(rst_n), .bus_style(bus_style), .cs_n(cs_n), .a0(a0),
        .en_rd(en_rd), .rw_wr(rw_wr), .d_in(d_in), .d_out(d_out), .d_oe(d_oe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One host access; got/oe are sampled while the strobe is still active.
    task automatic bus_op(input logic rd, input logic a_bit, input logic [7:0] d,
                          input logic sel, output logic [7:0] got, output logic oe);
        @(negedge clk);
        cs_n = !sel; a0 = a_bit; d_in = d;
        if (m68) begin rw_wr = rd; en_rd = 1'b1; end
        else if (rd) en_rd = 1'b0;
        else rw_wr = 1'b0;
        @(negedge clk);
        @(negedge clk);
        got = d_out; oe = d_oe;
        if (m68) en_rd = 1'b0;
        else begin en_rd = 1'b1; rw_wr = 1'b1; end
        @(negedge clk);
        cs_n = 1'b1;
        if (m68) rw_wr = 1'b1;
    endtask

    task automatic settle();
        repeat (BUSY_CYC + 2) @(negedge clk);
    endtask

    task automatic do_reset(input logic style);
        m68 = style; bus_style = style;
        en_rd = !style; rw_wr = 1'b1; cs_n = 1'b1;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #2ms;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] g;
        logic o;
        do_reset(1'b0);
        // R11 R9: idle bus is not driven; status shows display off, not busy.
        chk("R9 idle oe", {7'b0, d_oe}, 8'h00);
        bus_op(1'b1, 1'b0, 8'h00, 1'b1, g, o);
        chk("R11 R7 reset status", g, 8'h20);
        chk("R9 oe during RD", {7'b0, o}, 8'h01);
        // R11: first write lands at page 3 column 0.
        bus_op(1'b0, 1'b1, 8'h3C, 1'b1, g, o); settle();
        bus_op(1'b0, 1'b0, 8'hBB, 1'b1, g, o); settle();
        bus_op(1'b0, 1'b0, 8'h00, 1'b1, g, o); settle();
        bus_op(1'b1, 1'b1, 8'h00, 1'b1, g, o);
        bus_op(1'b1, 1'b1, 8'h00, 1'b1, g, o);
        chk("R11 reset page3 col0", g, 8'h3C);
        // R6 R7: display on clears status bit 5.
        bus_op(1'b0, 1'b0, 8'hAF, 1'b1, g, o); settle();
        bus_op(1'b1, 1'b0, 8'h00, 1'b1, g, o);
        chk("R6 display on status", g, 8'h00);

        // Vector table: R2 R3 R4 R5 R6 R12.
        for (int i = 0; i < NV; i++) begin
            logic [1:0] op;
            op = VEC[i][17:16];
            bus_op(op[1], (op != 2'd0), VEC[i][15:8], 1'b1, g, o);
            if (op == 2'd2) chk($sformatf("R3 R4 R5 R12 vec %0d", i), g, VEC[i][7:0]);
            settle();
        end

        // R8: command and status read inside the busy window.
        bus_op(1'b0, 1'b0, 8'hBA, 1'b1, g, o);
        bus_op(1'b0, 1'b0, 8'hB8, 1'b1, g, o);
        bus_op(1'b1, 1'b0, 8'h00, 1'b1, g, o);
        chk("R8 busy in status", g, 8'h80);
        settle();
        bus_op(1'b1, 1'b0, 8'h00, 1'b1, g, o);
        chk("R8 busy cleared", g, 8'h00);
        bus_op(1'b0, 1'b0, 8'h0A, 1'b1, g, o); settle();
        bus_op(1'b0, 1'b1, 8'h5A, 1'b1, g, o); settle();
        bus_op(1'b0, 1'b0, 8'hBA, 1'b1, g, o); settle();
        bus_op(1'b0, 1'b0, 8'h0A, 1'b1, g, o); settle();
        bus_op(1'b1, 1'b1, 8'h00, 1'b1, g, o);
        bus_op(1'b1, 1'b1, 8'h00, 1'b1, g, o);
        chk("R8 ignored page cmd", g, 8'h5A);

        // R10: chip select high blocks writes and bus drive.
        bus_op(1'b0, 1'b0, 8'hB8, 1'b1, g, o); settle();
        bus_op(1'b0, 1'b0, 8'h14, 1'b1, g, o); settle();
        bus_op(1'b0, 1'b1, 8'hEE, 1'b0, g, o); settle();
        bus_op(1'b1, 1'b1, 8'h00, 1'b0, g, o);
        chk("R10 no drive when deselected", {7'b0, o}, 8'h00);
        bus_op(1'b0, 1'b1, 8'h12, 1'b1, g, o); settle();
        bus_op(1'b0, 1'b0, 8'h14, 1'b1, g, o); settle();
        bus_op(1'b1, 1'b1, 8'h00, 1'b1, g, o);
        bus_op(1'b1, 1'b1, 8'h00, 1'b1, g, o);
        chk("R10 deselected write ignored", g, 8'h12);

        // R1: enable-mode bus after reset with the strap high.
        do_reset(1'b1);
        @(negedge clk);
        cs_n = 1'b0; a0 = 1'b1; rw_wr = 1'b1;
        @(negedge clk);
        chk("R1 no drive with E low", {7'b0, d_oe}, 8'h00);
        cs_n = 1'b1;
        bus_op(1'b1, 1'b0, 8'h00, 1'b1, g, o);
        chk("R1 enable-mode status", g, 8'h20);
        chk("R1 enable-mode oe", {7'b0, o}, 8'h01);
        bus_op(1'b0, 1'b0, 8'hB8, 1'b1, g, o); settle();
        bus_op(1'b0, 1'b0, 8'h02, 1'b1, g, o); settle();
        bus_op(1'b0, 1'b1, 8'h6C, 1'b1, g, o); settle();
        bus_op(1'b0, 1'b1, 8'h93, 1'b1, g, o); settle();
        bus_op(1'b0, 1'b0, 8'h02, 1'b1, g, o); settle();
        bus_op(1'b1, 1'b1, 8'h00, 1'b1, g, o);
        bus_op(1'b1, 1'b1, 8'h00, 1'b1, g, o);
        chk("R1 R3 enable-mode read 1", g, 8'h6C);
        bus_op(1'b1, 1'b1, 8'h00, 1'b1, g, o);
        chk("R1 R3 enable-mode read 2", g, 8'h93);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule